// File: doc/BRIEF.md
# ALU Status Flag Generator

This block turns one ALU result into the processor's condition flags and holds them in a 16-bit flag word. Each update cycle supplies both operands, the result, the carry or borrow reported by the adder, an operation class (add, subtract or logical) and a size select (byte or word). From these the block derives carry, parity, auxiliary carry, zero, sign and overflow. Three control flags (single-step trap, interrupt enable, string direction) live in the same word. Software writes them through a separate write strobe, and ALU updates never change them.

Two rules hold for both operand sizes. Parity always looks at the low byte of the result. Auxiliary carry always tracks the carry from bit 3 into bit 4. Zero, sign, carry and overflow follow the selected size. In byte mode the upper byte of every input is ignored.

Top module: `alu_flag_unit`

## Requirements
- R1: After reset the flag word reads 0x0000.
- R2: For op_class 0 (add) and 1 (subtract), the carry flag (bit 0) takes the value of carry_out, which is the carry or borrow out of the selected MSB. For op_class 2 and 3 (both logical), the carry flag is cleared.
- R3: The parity flag (bit 2) is set when the low byte of the result holds an even number of ones. This applies in both size modes and for every op_class.
- R4: For add and subtract, the auxiliary flag (bit 4) is set when there is a carry or borrow from bit 3 into bit 4, equal to opa[4]^opb[4]^result[4]. A logical update leaves the auxiliary flag at its previous value.
- R5: The zero flag (bit 6) is set when the result of the selected size is zero. wide=1 tests all 16 bits. wide=0 tests bits 7:0 only.
- R6: The sign flag (bit 7) copies result bit 15 when wide=1 and result bit 7 when wide=0.
- R7: For add and subtract, the overflow flag (bit 11) is the carry into the selected MSB XOR carry_out, which equals signed overflow. Logical updates clear it.
- R8: When ctl_we is high, trap (bit 8), interrupt enable (bit 9) and direction (bit 10) load from ctl_trap, ctl_int and ctl_dir. Status updates never alter these three bits, and control writes never alter the status bits.
- R9: Bits 1, 3, 5, 12, 13, 14 and 15 of the flag word always read 0. Each single-flag output equals its bit in the flag word.
- R10: While upd_en is low, the six status flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_en | input | 1 | Load status flags from this cycle's ALU result |
| op_class | input | 2 | 0 add, 1 subtract, 2/3 logical |
| wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| opa | input | 16 | First ALU operand |
| opb | input | 16 | Second ALU operand |
| res | input | 16 | ALU result |
| carry_out | input | 1 | Carry (add) or borrow (subtract) out of the selected MSB |
| ctl_we | input | 1 | Write strobe for the control flags |
| ctl_trap | input | 1 | New single-step trap value |
| ctl_int | input | 1 | New interrupt-enable value |
| ctl_dir | input | 1 | New direction value (1 = auto-decrement) |
| flag_word | output | 16 | Packed flag register |
| flag_cf | output | 1 | Carry flag |
| flag_pf | output | 1 | Parity flag |
| flag_af | output | 1 | Auxiliary carry flag |
| flag_zf | output | 1 | Zero flag |
| flag_sf | output | 1 | Sign flag |
| flag_of | output | 1 | Overflow flag |
| flag_tf | output | 1 | Trap flag |
| flag_if | output | 1 | Interrupt-enable flag |
| flag_df | output | 1 | Direction flag |

## Verification
Both register groups have one stage. A status update or a control write that is presented before a rising edge shows on flag_word and on the single-flag outputs right after that edge.

The bench drives each stimulus on a falling edge and holds upd_en or ctl_we for exactly one cycle. It compares the outputs on the next falling edge against expected values computed by its own arithmetic:
- signed-overflow rules from operand and result signs;
- nibble sums and differences for the auxiliary flag;
- ones counting for parity.

Between updates it checks that the flags are unchanged.

// File: rtl/flagu_pkg.sv
package flagu_pkg;
  localparam int FLAG_W = 16;
  localparam int POS_CF = 0;
  localparam int POS_PF = 2;
  localparam int POS_AF = 4;
  localparam int POS_ZF = 6;
  localparam int POS_SF = 7;
  localparam int POS_TF = 8;
  localparam int POS_IF = 9;
  localparam int POS_DF = 10;
  localparam int POS_OF = 11;

  typedef enum logic [1:0] {
    OPC_ADD  = 2'd0,
    OPC_SUB  = 2'd1,
    OPC_LOG  = 2'd2,
    OPC_LOG2 = 2'd3
  } op_class_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zer;
    logic aux;
    logic par;
    logic cry;
  } status_t;

  typedef struct packed {
    logic dir;
    logic ien;
    logic trp;
  } ctrl_t;
endpackage

// File: rtl/flagu_status_calc.sv
module flagu_status_calc
  import flagu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic [WORD_W-1:0] res,
  input  logic              carry_out,
  input  logic [1:0]        op_class,
  input  logic              wide,
  output status_t           nxt,
  output logic              is_logic,
  output logic              msb_cin,
  output logic              nib_carry
);
  localparam int LOW_W = WORD_W / 2;
  localparam int NIB_W = LOW_W / 2;

  // carry (or borrow) entering bit idx, recovered from sum bit identity
  function automatic logic carry_into(input logic [WORD_W-1:0] a,
                                      input logic [WORD_W-1:0] b,
                                      input logic [WORD_W-1:0] r,
                                      input int idx);
    return a[idx] ^ b[idx] ^ r[idx];
  endfunction

  function automatic logic low_even(input logic [WORD_W-1:0] r);
    return ~^r[LOW_W-1:0];
  endfunction

  function automatic logic sized_zero(input logic [WORD_W-1:0] r, input logic w);
    return w ? (r == '0) : (r[LOW_W-1:0] == '0);
  endfunction

  function automatic logic sized_msb(input logic [WORD_W-1:0] r, input logic w);
    return w ? r[WORD_W-1] : r[LOW_W-1];
  endfunction

  op_class_e cls;

  always_comb begin
    cls       = op_class_e'(op_class);
    is_logic  = (cls == OPC_LOG) || (cls == OPC_LOG2);
    msb_cin   = carry_into(opa, opb, res, wide ? WORD_W-1 : LOW_W-1);
    nib_carry = carry_into(opa, opb, res, NIB_W);
    nxt.par   = low_even(res);
    nxt.zer   = sized_zero(res, wide);
    nxt.sgn   = sized_msb(res, wide);
    nxt.aux   = nib_carry;
    nxt.cry   = is_logic ? 1'b0 : carry_out;
    nxt.ovf   = is_logic ? 1'b0 : (msb_cin ^ carry_out);
  end
endmodule

// File: rtl/flagu_status_reg.sv
module flagu_status_reg
  import flagu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    upd_en,
  input  logic    is_logic,
  input  status_t nxt,
  output status_t cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (upd_en) begin
      cur.cry <= nxt.cry;
      cur.par <= nxt.par;
      cur.zer <= nxt.zer;
      cur.sgn <= nxt.sgn;
      cur.ovf <= nxt.ovf;
      if (!is_logic) cur.aux <= nxt.aux;
    end
  end

  // R10: no update request, no change
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(cur));
  // R2: logical class clears carry
  p_logic_cf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && is_logic) |=> !cur.cry);
  // R4: logical class keeps auxiliary carry
  p_logic_af_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && is_logic) |=> (cur.aux == $past(cur.aux)));
  // R7: logical class clears overflow
  p_logic_of_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && is_logic) |=> !cur.ovf);
endmodule

// File: rtl/flagu_ctrl_reg.sv
module flagu_ctrl_reg
  import flagu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  ctrl_t wdata,
  output ctrl_t cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cur <= '0;
    else if (we) cur <= wdata;
  end

  // R8: control flags change only on an explicit write
  p_ctl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cur));
  p_ctl_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cur == $past(wdata)));
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import flagu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [1:0]        op_class,
  input  logic              wide,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic [WORD_W-1:0] res,
  input  logic              carry_out,
  input  logic              ctl_we,
  input  logic              ctl_trap,
  input  logic              ctl_int,
  input  logic              ctl_dir,
  output logic [FLAG_W-1:0] flag_word,
  output logic              flag_cf,
  output logic              flag_pf,
  output logic              flag_af,
  output logic              flag_zf,
  output logic              flag_sf,
  output logic              flag_of,
  output logic              flag_tf,
  output logic              flag_if,
  output logic              flag_df
);
  localparam int LOW_W = WORD_W / 2;

  status_t st_nxt, st_cur;
  ctrl_t   ct_cur, ct_wr;
  logic    is_logic, msb_cin, nib_carry;

  assign ct_wr = '{dir: ctl_dir, ien: ctl_int, trp: ctl_trap};

  flagu_status_calc #(.WORD_W(WORD_W)) u_calc (
    .opa(opa), .opb(opb), .res(res), .carry_out(carry_out),
    .op_class(op_class), .wide(wide), .nxt(st_nxt),
    .is_logic(is_logic), .msb_cin(msb_cin), .nib_carry(nib_carry)
  );

  flagu_status_reg u_sreg (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .is_logic(is_logic),
    .nxt(st_nxt), .cur(st_cur)
  );

  flagu_ctrl_reg u_creg (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ct_wr), .cur(ct_cur)
  );

  always_comb begin
    flag_word         = '0;
    flag_word[POS_CF] = st_cur.cry;
    flag_word[POS_PF] = st_cur.par;
    flag_word[POS_AF] = st_cur.aux;
    flag_word[POS_ZF] = st_cur.zer;
    flag_word[POS_SF] = st_cur.sgn;
    flag_word[POS_OF] = st_cur.ovf;
    flag_word[POS_TF] = ct_cur.trp;
    flag_word[POS_IF] = ct_cur.ien;
    flag_word[POS_DF] = ct_cur.dir;
  end

  assign flag_cf = flag_word[POS_CF];
  assign flag_pf = flag_word[POS_PF];
  assign flag_af = flag_word[POS_AF];
  assign flag_zf = flag_word[POS_ZF];
  assign flag_sf = flag_word[POS_SF];
  assign flag_of = flag_word[POS_OF];
  assign flag_tf = flag_word[POS_TF];
  assign flag_if = flag_word[POS_IF];
  assign flag_df = flag_word[POS_DF];

  // R6: sign follows the MSB of the selected size
  p_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (flag_sf == $past(wide ? res[WORD_W-1] : res[LOW_W-1])));
  // R3: parity of the low byte in both sizes
  p_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (flag_pf == ($countones($past(res[LOW_W-1:0])) % 2 == 0)));
  // R7: arithmetic overflow is carry-in XOR carry-out at the MSB
  p_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !is_logic) |=> (flag_of == $past(msb_cin ^ carry_out)));
  // R8: status updates leave control flags alone
  p_ctl_iso_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !ctl_we) |=> $stable(flag_word[POS_DF:POS_TF]));
endmodule

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic upd_en = 0, wide = 0, carry_out = 0;
  logic [1:0] op_class = 0;
  logic [15:0] opa = 0, opb = 0, res = 0;
  logic ctl_we = 0, ctl_trap = 0, ctl_int = 0, ctl_dir = 0;
  logic [15:0] flag_word;
  logic f_cf, f_pf, f_af, f_zf, f_sf, f_of, f_tf, f_if, f_df;

  int errors = 0, checks = 0;
  logic [15:0] exp_word = 0;

  alu_flag_unit i_alu_flag_unit (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_class(op_class),
    .wide(wide), .opa(opa), .opb(opb), .res(res), .carry_out(carry_out),
    .ctl_we(ctl_we), .ctl_trap(ctl_trap), .ctl_int(ctl_int), .ctl_dir(ctl_dir),
    .flag_word(flag_word), .flag_cf(f_cf), .flag_pf(f_pf), .flag_af(f_af),
    .flag_zf(f_zf), .flag_sf(f_sf), .flag_of(f_of), .flag_tf(f_tf),
    .flag_if(f_if), .flag_df(f_df)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic check_all();
    chk({15'd0, f_cf}, {15'd0, exp_word[0]},  "R2 carry");
    chk({15'd0, f_pf}, {15'd0, exp_word[2]},  "R3 parity");
    chk({15'd0, f_af}, {15'd0, exp_word[4]},  "R4 aux");
    chk({15'd0, f_zf}, {15'd0, exp_word[6]},  "R5 zero");
    chk({15'd0, f_sf}, {15'd0, exp_word[7]},  "R6 sign");
    chk({15'd0, f_of}, {15'd0, exp_word[11]}, "R7 overflow");
    chk({13'd0, f_df, f_if, f_tf}, {13'd0, exp_word[10:8]}, "R8 control");
    chk(flag_word, exp_word, "R9 word");
  endtask

  // expected status from signed/unsigned arithmetic, not bit identities
  task automatic model_update(input logic [15:0] a, input logic [15:0] b,
                              input logic [15:0] r, input logic co,
                              input logic [1:0] cls, input logic w);
    logic sa, sb, sr, lg;
    lg = cls[1];
    sa = w ? a[15] : a[7];
    sb = w ? b[15] : b[7];
    sr = w ? r[15] : r[7];
    exp_word[2] = ($countones(r[7:0]) % 2) == 0;
    exp_word[6] = w ? (r == 16'd0) : (r[7:0] == 8'd0);
    exp_word[7] = sr;
    if (lg) begin
      exp_word[0] = 1'b0;
      exp_word[11] = 1'b0;
    end else begin
      exp_word[0] = co;
      if (cls == 2'd0) begin
        exp_word[4] = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
        exp_word[11] = (sa == sb) && (sr != sa);
      end else begin
        exp_word[4] = a[3:0] < b[3:0];
        exp_word[11] = (sa != sb) && (sr != sa);
      end
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b,
                       input logic [1:0] cls, input logic w);
    logic [15:0] r;
    logic co;
    if (cls == 2'd0) begin
      if (w) {co, r} = {1'b0, a} + {1'b0, b};
      else begin
        {co, r[7:0]} = {1'b0, a[7:0]} + {1'b0, b[7:0]};
        r[15:8] = 8'($urandom);
      end
    end else if (cls == 2'd1) begin
      if (w) begin r = a - b; co = a < b; end
      else begin
        r[7:0] = a[7:0] - b[7:0];
        co = a[7:0] < b[7:0];
        r[15:8] = 8'($urandom);
      end
    end else begin
      case ($urandom % 3)
        0: r = a & b;
        1: r = a | b;
        default: r = a ^ b;
      endcase
      co = 1'($urandom);
    end
    @(negedge clk);
    opa = a; opb = b; res = r; carry_out = co; op_class = cls; wide = w;
    upd_en = 1;
    model_update(a, b, r, co, cls, w);
    @(negedge clk);
    upd_en = 0;
    check_all();
  endtask

  task automatic ctl_write(input logic t, input logic i, input logic d);
    @(negedge clk);
    ctl_we = 1; ctl_trap = t; ctl_int = i; ctl_dir = d;
    exp_word[8] = t; exp_word[9] = i; exp_word[10] = d;
    @(negedge clk);
    ctl_we = 0;
    check_all();
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (2) @(negedge clk);
    chk(flag_word, 16'h0000, "R1 reset word");
    rst_n = 1;
    @(negedge clk);
    chk(flag_word, 16'h0000, "R1 after release");

    // directed corners
    apply(16'h7FFF, 16'h0001, 2'd0, 1'b1);  // word OF, SF, AF
    apply(16'h12FF, 16'h3401, 2'd0, 1'b0);  // byte carry, zero from low byte
    apply(16'hFF00, 16'h0000, 2'd2, 1'b0);  // R5: upper byte ignored, logic keeps AF=1
    apply(16'h0000, 16'h0001, 2'd1, 1'b1);  // borrow, word sign
    apply(16'h0080, 16'h0001, 2'd1, 1'b0);  // byte signed overflow on subtract
    apply(16'h8000, 16'h8000, 2'd0, 1'b1);  // word carry + overflow + zero
    apply(16'hF0F0, 16'h0F0F, 2'd3, 1'b1);  // class 3 is logical
    ctl_write(1'b1, 1'b0, 1'b1);
    apply(16'h1234, 16'h4321, 2'd0, 1'b1);  // R8: control bits survive update
    ctl_write(1'b0, 1'b1, 1'b0);            // R8: status bits survive write

    // R10: idle cycles hold everything
    @(negedge clk);
    opa = 16'hFFFF; opb = 16'hFFFF; res = 16'h0000; carry_out = 1; op_class = 0;
    repeat (3) @(negedge clk);
    check_all();

    for (int n = 0; n < 400; n++) begin
      if (n % 37 == 0)
        ctl_write(1'($urandom), 1'($urandom), 1'($urandom));
      apply(16'($urandom), 16'($urandom), 2'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule